// File: doc/BRIEF.md
# Serial Multiplexed Seven-Segment Display Controller

This block drives five seven-segment digits plus their decimal points from a three-wire serial port: a data line, a shift clock whose rising edge samples the data, and an active-low enable. While the enable is low, each rising shift-clock edge moves one bit into a 24-bit shift register, most significant bit first. When the enable returns high, the number of edges counted in that frame decides what happens. A frame whose length is 8 modulo 24 writes the last eight bits into an 8-bit setup register. A non-zero multiple of 24 writes the last 24 bits into the display register. Any other length changes nothing. The serial output carries the bit shifted in 24 edges earlier, so several controllers can be daisy-chained. The word for the far end of the chain is sent first.

The digits are scanned one at a time. Each bank is driven for `SLOT_CYCLES` system clocks, and the scan runs bank 1 to bank 5 and then wraps. Each bank's nibble is turned into a segment pattern by one of three decoders: hex, a special-character set, or raw. The setup register picks the decoder per bank, or overrides the choice for all banks. A brightness bit can halve the on-time of every slot. The serial lines are sampled by the system clock through synchronizers, so the shift clock must stay high and low for at least four system clocks per phase. The serial port has no back-pressure. Every qualifying edge is taken at once, and nothing is ever refused.

Top module: `seg7_mux_driver`

## Requirements
- R1: After reset, `seg_o`, `dp_o`, `bank_o` and `ser_dout` are all zero.
- R2: A frame of 8 edges (or 32, 56, ...) copies the last eight bits received into the setup register when `ser_en_n` rises. Bits arrive MSB first.
- R3: A frame of 24 edges (or 48, 72, ...) copies the last 24 bits received into the display register. Bits 19:0 hold five nibbles, bank 5 in bits 19:16 down to bank 1 in bits 3:0.
- R4: A frame of any other length (for example 5 or 16 edges) leaves both registers unchanged.
- R5: While setup bit 0 is 0 (the reset value), `seg_o`, `dp_o` and `bank_o` are all zero.
- R6: When enabled, exactly one bit of `bank_o` is high. Bit 0 is bank 1. Each bank stays active for exactly `SLOT_CYCLES` clocks, and the scan advances bit 0 → 1 → 2 → 3 → 4 → 0.
- R7: With no override, setup bit k (k = 1..5) at 0 selects hex decode for bank k. `seg_o` bit 0 is segment a through bit 6 is segment g. The hex codes 0..F give 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R8: Setup bit k at 1 selects special decode for bank k. The codes 0..F give 00 58 76 74 1E 38 54 5C 73 50 3E 1C 6E 40 48 63 (blank, c, H, h, J, L, n, o, P, r, U, u, y, minus, equals, degree).
- R9: Setup bits 7:6 override the per-bank choice. 00 means no override. 01 forces hex on all banks, 10 forces special on all banks. 11 drives the nibble raw onto segments a..d (nibble bit 0 to a) with e..g off.
- R10: Display bit 23 at 1 means bright: segments stay lit for the whole slot. At 0 (dim), `seg_o` and `dp_o` are lit only during the first `SLOT_CYCLES/2` clocks of each slot and are zero for the rest.
- R11: Display bits 22:20 hold a bank number 1..5 whose decimal point `dp_o` is lit. The values 0, 6 and 7 light no decimal point.
- R12: `ser_dout` shows the bit received 24 shift edges earlier, updated after each shift, so that a chained controller sees the earlier words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, rising edge samples `ser_din` |
| ser_din | input | 1 | Serial data in, MSB first |
| ser_en_n | input | 1 | Active-low frame enable; rising edge commits the frame |
| ser_dout | output | 1 | Serial data out to the next controller in a chain |
| seg_o | output | 7 | Segments a..g (bit 0 = a), active high |
| dp_o | output | 1 | Decimal-point segment of the active bank |
| bank_o | output | 5 | One-hot bank select, bit 0 = bank 1 |

## Verification
The bench targets the frame-length rule at its edges. It sends 5- and 16-edge frames that must change nothing. It sends 32- and 56-edge chained frames, where a design that compared the raw count with 8 or 24 would drop the update, and a 48-edge display frame. It checks the shift-out path bit by bit after a display load; a wrong tap or an off-by-one delay would show the wrong bit on `ser_dout`. Each scan slot is timed against its length, and the dim half-slot boundary is checked cycle by cycle. A slot counter off by one would light a segment one cycle too long or rotate early. The decoder override codes are run with per-bank select bits set against them. A design that let the per-bank bits win would then show the wrong glyph set.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int NUM_BANKS  = 5;
  localparam int NIB_W      = 4;
  localparam int SEG_W      = 7;
  localparam int CFG_W      = 8;
  localparam int DISP_W     = 24;
  localparam int NIBS_W     = NUM_BANKS * NIB_W;
  localparam int BRIGHT_BIT = DISP_W - 1;
  localparam int DP_LSB     = NIBS_W;
  localparam int DP_W       = BRIGHT_BIT - DP_LSB;
  localparam int IDX_W      = $clog2(NUM_BANKS);

  typedef enum logic [1:0] {
    OVR_NONE    = 2'b00,
    OVR_HEX     = 2'b01,
    OVR_SPECIAL = 2'b10,
    OVR_RAW     = 2'b11
  } ovr_mode_e;

  function automatic logic [SEG_W-1:0] hex_glyph(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: hex_glyph = 7'h3F;  4'h1: hex_glyph = 7'h06;
      4'h2: hex_glyph = 7'h5B;  4'h3: hex_glyph = 7'h4F;
      4'h4: hex_glyph = 7'h66;  4'h5: hex_glyph = 7'h6D;
      4'h6: hex_glyph = 7'h7D;  4'h7: hex_glyph = 7'h07;
      4'h8: hex_glyph = 7'h7F;  4'h9: hex_glyph = 7'h6F;
      4'hA: hex_glyph = 7'h77;  4'hB: hex_glyph = 7'h7C;
      4'hC: hex_glyph = 7'h39;  4'hD: hex_glyph = 7'h5E;
      4'hE: hex_glyph = 7'h79;  default: hex_glyph = 7'h71;
    endcase
  endfunction

  function automatic logic [SEG_W-1:0] special_glyph(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: special_glyph = 7'h00;  4'h1: special_glyph = 7'h58;
      4'h2: special_glyph = 7'h76;  4'h3: special_glyph = 7'h74;
      4'h4: special_glyph = 7'h1E;  4'h5: special_glyph = 7'h38;
      4'h6: special_glyph = 7'h54;  4'h7: special_glyph = 7'h5C;
      4'h8: special_glyph = 7'h73;  4'h9: special_glyph = 7'h50;
      4'hA: special_glyph = 7'h3E;  4'hB: special_glyph = 7'h1C;
      4'hC: special_glyph = 7'h6E;  4'hD: special_glyph = 7'h40;
      4'hE: special_glyph = 7'h48;  default: special_glyph = 7'h63;
    endcase
  endfunction
endpackage

// File: rtl/seg7_serial_rx.sv
module seg7_serial_rx
  import seg7_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_en_n,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [DISP_W-1:0] disp_q,
  output logic              sdout
);
  localparam int POS_W = $clog2(DISP_W);
  localparam logic [2:0] IDLE_LINES = 3'b100;

  // [2] enable, [1] data, [0] clock
  logic [SYNC_STAGES:0][2:0] pipe_q;
  logic [2:0] cur, prev;
  logic clk_rise, en_rise, en_low;
  logic [DISP_W-1:0] shreg_q;
  logic [POS_W-1:0]  pos_q;
  logic              wrapped_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= SYNC_STAGES; i++) pipe_q[i] <= IDLE_LINES;
    end else begin
      pipe_q <= {pipe_q[SYNC_STAGES-1:0], {ser_en_n, ser_din, ser_clk}};
    end
  end

  assign cur      = pipe_q[SYNC_STAGES-1];
  assign prev     = pipe_q[SYNC_STAGES];
  assign clk_rise = cur[0] & ~prev[0];
  assign en_rise  = cur[2] & ~prev[2];
  assign en_low   = ~cur[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q   <= '0;
      pos_q     <= '0;
      wrapped_q <= 1'b0;
      cfg_q     <= '0;
      disp_q    <= '0;
    end else if (en_rise) begin
      if (pos_q == POS_W'(CFG_W)) cfg_q <= shreg_q[CFG_W-1:0];
      if (pos_q == '0 && wrapped_q) disp_q <= shreg_q;
      pos_q     <= '0;
      wrapped_q <= 1'b0;
    end else if (clk_rise && en_low) begin
      shreg_q <= {shreg_q[DISP_W-2:0], cur[1]};
      if (pos_q == POS_W'(DISP_W - 1)) begin
        pos_q     <= '0;
        wrapped_q <= 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign sdout = shreg_q[DISP_W-1];

  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rise |=> $stable(cfg_q));
  assert_disp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rise |=> $stable(disp_q));
  assert_chain_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_rise && en_low && !en_rise) |=> sdout == $past(shreg_q[DISP_W-2]));
endmodule

// File: rtl/seg7_scan.sv
module seg7_scan
  import seg7_pkg::*;
#(
  parameter int SLOT_CYCLES = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [IDX_W-1:0]     idx_q,
  output logic [NUM_BANKS-1:0] bank_oh,
  output logic                 first_half
);
  localparam int CNT_W = $clog2(SLOT_CYCLES);
  localparam int HALF  = SLOT_CYCLES / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      idx_q <= (idx_q == IDX_W'(NUM_BANKS - 1)) ? '0 : idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_oh
    assign bank_oh[i] = (idx_q == IDX_W'(i));
  end

  assign first_half = (cnt_q < CNT_W'(HALF));

  assert_bank_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(NUM_BANKS));
  assert_slot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> $stable(idx_q));
endmodule

// File: rtl/seg7_glyph.sv
module seg7_glyph
  import seg7_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  input  logic             use_special,
  input  logic             use_raw,
  output logic [SEG_W-1:0] glyph
);
  always_comb begin
    if (use_raw)          glyph = {{(SEG_W-NIB_W){1'b0}}, nib};
    else if (use_special) glyph = special_glyph(nib);
    else                  glyph = hex_glyph(nib);
  end
endmodule

// File: rtl/seg7_mux_driver.sv
module seg7_mux_driver
  import seg7_pkg::*;
#(
  parameter int SLOT_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_din,
  input  logic                 ser_en_n,
  output logic                 ser_dout,
  output logic [SEG_W-1:0]     seg_o,
  output logic                 dp_o,
  output logic [NUM_BANKS-1:0] bank_o
);
  logic [CFG_W-1:0]     cfg_q;
  logic [DISP_W-1:0]    disp_q;
  logic [IDX_W-1:0]     idx;
  logic [NUM_BANKS-1:0] oh;
  logic                 first_half;
  logic [NIB_W-1:0]     nib_sel;
  logic                 use_special, use_raw;
  logic [SEG_W-1:0]     glyph;
  logic                 dp_hit, lit, on;
  ovr_mode_e            ovr;

  seg7_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_en_n(ser_en_n), .cfg_q(cfg_q), .disp_q(disp_q), .sdout(ser_dout)
  );

  seg7_scan #(.SLOT_CYCLES(SLOT_CYCLES)) u_scan (
    .clk(clk), .rst_n(rst_n), .idx_q(idx), .bank_oh(oh), .first_half(first_half)
  );

  always_comb begin
    nib_sel = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (idx == IDX_W'(i)) nib_sel = disp_q[i*NIB_W +: NIB_W];
  end

  assign ovr = ovr_mode_e'(cfg_q[CFG_W-1 -: 2]);

  always_comb begin
    use_raw     = 1'b0;
    use_special = 1'b0;
    case (ovr)
      OVR_HEX:     use_special = 1'b0;
      OVR_SPECIAL: use_special = 1'b1;
      OVR_RAW:     use_raw     = 1'b1;
      default: begin
        for (int i = 0; i < NUM_BANKS; i++)
          if (idx == IDX_W'(i)) use_special = cfg_q[i+1];
      end
    endcase
  end

  seg7_glyph u_glyph (
    .nib(nib_sel), .use_special(use_special), .use_raw(use_raw), .glyph(glyph)
  );

  assign dp_hit = (disp_q[DP_LSB +: DP_W] == DP_W'(idx) + DP_W'(1));
  assign lit    = disp_q[BRIGHT_BIT] | first_half;
  assign on     = cfg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_o  <= '0;
      dp_o   <= 1'b0;
      bank_o <= '0;
    end else begin
      seg_o  <= (on && lit) ? glyph : '0;
      dp_o   <= on && lit && dp_hit;
      bank_o <= on ? oh : '0;
    end
  end

  assert_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[0] |=> (seg_o == '0 && !dp_o && bank_o == '0));
  assert_dim_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[0] && !disp_q[BRIGHT_BIT] && !first_half) |=> (seg_o == '0 && !dp_o));
  assert_one_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_o));
endmodule

// File: tb/seg7_mux_driver_bench.sv
module seg7_mux_driver_bench;
  localparam int SLOT = 8;
  localparam int HALF_SER = 6;

  typedef struct packed { logic [7:0] c; logic [23:0] d; } state_t;

  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_din = 0, ser_en_n = 1;
  logic ser_dout, dp_o;
  logic [6:0] seg_o;
  logic [4:0] bank_o;

  int n_checks = 0, n_fail = 0;
  logic [7:0]  mcfg  = 8'h00;
  logic [23:0] mdisp = 24'h0;
  state_t q[$];
  bit mon_busy = 0;

  always #4 clk = ~clk;

  seg7_mux_driver #(.SLOT_CYCLES(SLOT)) u_seg7_mux_driver (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_en_n(ser_en_n), .ser_dout(ser_dout), .seg_o(seg_o), .dp_o(dp_o),
    .bank_o(bank_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] t_hex(input logic [3:0] n);
    logic [6:0] t [16] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                           7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
    return t[n];
  endfunction
  function automatic logic [6:0] t_spc(input logic [3:0] n);
    logic [6:0] t [16] = '{7'h00,7'h58,7'h76,7'h74,7'h1E,7'h38,7'h54,7'h5C,
                           7'h73,7'h50,7'h3E,7'h1C,7'h6E,7'h40,7'h48,7'h63};
    return t[n];
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shift_bit(input logic b);
    ser_din = b;
    cyc(HALF_SER); ser_clk = 1;
    cyc(HALF_SER); ser_clk = 0;
  endtask

  task automatic open_frame();  ser_en_n = 0; cyc(4);  endtask
  task automatic close_frame(); cyc(2); ser_en_n = 1; cyc(12); endtask

  // driver: sends a frame, updates model, pushes expected state
  task automatic send_frame(input logic [63:0] bits, input int n);
    open_frame();
    for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
    close_frame();
    if (n % 24 == 8) mcfg = bits[7:0];
    else if (n >= 24 && n % 24 == 0) mdisp = bits[23:0];
    q.push_back('{c: mcfg, d: mdisp});
    cyc(1);
    wait (q.size() == 0 && !mon_busy);
  endtask

  function automatic int oh_idx(input logic [4:0] b);
    for (int i = 0; i < 5; i++) if (b == 5'(1 << i)) return i;
    return -1;
  endfunction

  // monitor: pops expected state, checks a full scan rotation
  initial begin
    state_t s;
    forever begin
      wait (q.size() > 0);
      mon_busy = 1;
      s = q.pop_front();
      cyc(4);
      if (!s.c[0]) begin
        for (int k = 0; k < 5 * SLOT; k++) begin
          @(negedge clk);
          chk(seg_o == 0 && !dp_o && bank_o == 0, "R5 blank outputs", {seg_o, dp_o, bank_o}, 0);
        end
      end else begin
        logic [4:0] prev;
        int c, w;
        @(negedge clk); prev = bank_o; w = 0;
        while (bank_o == prev && w < 3 * SLOT) begin @(negedge clk); w++; end
        chk(bank_o != prev, "R6 scan advances", bank_o, prev);
        c = 0;
        for (int k = 0; k < 5 * SLOT; k++) begin
          int idx;
          logic [3:0] nib;
          logic [6:0] eg;
          logic lit, ed, spc;
          if (k > 0) begin
            @(negedge clk);
            if (bank_o != prev) begin
              chk(bank_o == {prev[3:0], prev[4]}, "R6 scan order", bank_o, {prev[3:0], prev[4]});
              chk(c + 1 == SLOT, "R6 slot length", c + 1, SLOT);
              c = 0;
            end else c++;
          end
          prev = bank_o;
          idx = oh_idx(bank_o);
          chk(idx >= 0, "R6 one-hot bank", bank_o, 0);
          if (idx < 0) idx = 0;
          nib = s.d[idx*4 +: 4];
          case (s.c[7:6])
            2'b01: spc = 0;
            2'b10: spc = 1;
            default: spc = s.c[idx+1];
          endcase
          eg = (s.c[7:6] == 2'b11) ? {3'b000, nib} : (spc ? t_spc(nib) : t_hex(nib));
          lit = s.d[23] || (c < SLOT / 2);
          ed = lit && (s.d[22:20] == 3'(idx + 1));
          if (!lit) eg = 0;
          chk(seg_o == eg, s.c[7:6] != 0 ? "R9 override glyph" :
                           (spc ? "R8 special glyph" : "R7 hex glyph / R10 dim"), seg_o, eg);
          chk(dp_o == ed, "R11 decimal point / R10 dim", dp_o, ed);
        end
      end
      mon_busy = 0;
    end
  end

  initial begin
    fork
      begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    join_none
    cyc(3); rst_n = 1; cyc(2);
    @(negedge clk);
    chk(seg_o == 0 && !dp_o && bank_o == 0 && !ser_dout, "R1 reset outputs",
        {seg_o, dp_o, bank_o, ser_dout}, 0);
    #1;
    // R3 load while blank (R5): bright, dp bank 2, nibbles 1..5
    send_frame(64'hA12345, 24);
    // R2 config: enable, all hex
    send_frame(64'h01, 8);
    // R8 per-bank special on banks 2 and 4 (R7 others)
    send_frame(64'h15, 8);
    // R10 dim, dp bank 5, special codes
    send_frame(64'h5FD920, 24);
    // R9 overrides
    send_frame(64'h81, 8);
    send_frame(64'h7F, 8);
    send_frame(64'hC1, 8);
    // R4 odd-length frames do nothing
    send_frame(64'h1234, 16);
    send_frame(64'h1B, 5);
    // R12 shift-out: load display, then watch it leave
    send_frame(64'hB6E1C7, 24);
    begin
      logic [23:0] d = 24'hB6E1C7;
      open_frame();
      chk(ser_dout == d[23], "R12 chain out before shift", ser_dout, d[23]);
      for (int k = 1; k <= 8; k++) begin
        shift_bit(k[0]);
        chk(ser_dout == d[23-k], "R12 chain out", ser_dout, d[23-k]);
      end
      close_frame();
      mcfg = 8'hAA;
      q.push_back('{c: mcfg, d: mdisp});
      cyc(1);
      wait (q.size() == 0 && !mon_busy);
    end
    // R12/R2 chained frames: 32 and 56 edges set config, 48 sets display
    send_frame(64'hFF_03, 32);
    send_frame(64'h00FFFF_876543, 48);
    send_frame(64'h45_000000_000001, 56);
    // R5 disable again
    send_frame(64'h00, 8);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule